// File: doc/BRIEF.md
# Reservation Monitor for Conditional Stores

This block keeps one processor's reservation for a load-reserve / store-conditional pair on a snooping bus. A load-reserve marks a word address as reserved and sends an ordinary read to memory. A later store-conditional to that same word sends an ordinary write and reports success, but only if the reservation is still intact. Otherwise it reports failure and issues no write.

The monitor watches store traffic from the other processors on the bus. A store that hits the reserved word cancels the reservation. This replaces locking the bus for a whole read-modify-write. Each monitor holds its own reservation, so several processors can reserve the same word at once. When a store-conditional succeeds, the monitor puts the stored word address on a broadcast port so that its peers drop any reservation they hold on that word.

Memory and the bus fabric sit outside the block. All outputs are registered and appear one clock after the command that causes them.

Top module: `resv_monitor`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, every output is 0. A store-conditional issued before any load-reserve fails.
- R2: A load-reserve (`lr_valid`) sets the reservation and latches the word address. In the next cycle it drives `rd_en`=1 with `rd_addr` equal to `lr_addr`.
- R3: A store-conditional (`sc_valid`) passes when a reservation is held on the same word. In the next cycle the block drives `st_en`=1, `st_addr`=`sc_addr`, `st_data`=`sc_data`, `sc_done`=1 and `sc_ok`=1.
- R4: A store-conditional that does not pass drives `sc_done`=1, `sc_ok`=0 and `st_en`=0 in the next cycle.
- R5: Addresses are compared per 32-bit word. The byte-offset bits [1:0] are ignored, and any difference in bits [31:2] is a mismatch.
- R6: A snooped store (`snp_valid`) whose word matches the reservation clears it. A snooped store to any other word leaves it intact.
- R7: A matching snooped store in the same cycle as a store-conditional wins, so that store-conditional fails.
- R8: Every store-conditional clears the reservation, whether it passes or fails.
- R9: A passing store-conditional drives `bcast_valid`=1 in the next cycle, with `bcast_addr` equal to `sc_addr` with bits [1:0] forced to 0. `bcast_valid` is 0 in every other cycle.
- R10: A store-conditional is judged on the reservation held before its cycle. A load-reserve in the same cycle as a store-conditional or a snooped store still leaves the new reservation set.
- R11: A new load-reserve replaces the reserved address. A later store-conditional to the old word fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lr_valid | input | 1 | Load-reserve command |
| lr_addr | input | 32 | Load-reserve byte address |
| sc_valid | input | 1 | Store-conditional command |
| sc_addr | input | 32 | Store-conditional byte address |
| sc_data | input | 32 | Store-conditional write data |
| snp_valid | input | 1 | Store by another processor seen on the bus |
| snp_addr | input | 32 | Address of the snooped store |
| rd_en | output | 1 | Read request issued for a load-reserve |
| rd_addr | output | 32 | Read address |
| st_en | output | 1 | Write request issued for a passing store-conditional |
| st_addr | output | 32 | Write address |
| st_data | output | 32 | Write data |
| sc_done | output | 1 | Store-conditional result is valid |
| sc_ok | output | 1 | Store-conditional passed |
| bcast_valid | output | 1 | Broadcast that cancels peers' reservations |
| bcast_addr | output | 32 | Word-aligned address of the broadcast |

## Verification
Two events can land in the same cycle: a store-conditional may be judged while a snooped store cancels the reservation it depends on, and a load-reserve may arrive while a store-conditional or snoop clears the flag. The bench drives these pairs together in a single cycle. It first uses a matching word and then a neighbouring word, then checks the result flags and the write request one cycle later. A follow-up store-conditional then shows which reservation survived.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef struct packed {
    logic done;
    logic ok;
  } sc_result_t;
endpackage

// File: rtl/resv_addr_cmp.sv
module resv_addr_cmp #(
  parameter int AW  = 32,
  parameter int OFS = 2
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic          same_word
);
  logic [AW-1:0] diff;
  always_comb begin
    diff      = (a ^ b) >> OFS;
    same_word = (diff == '0);
  end
endmodule

// File: rtl/resv_state.sv
module resv_state #(
  parameter int AW  = 32,
  parameter int OFS = 2,
  localparam int WW = AW - OFS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lr_valid,
  input  logic [WW-1:0] lr_word,
  input  logic          sc_valid,
  input  logic          snp_clear,
  output logic          flag,
  output logic [WW-1:0] resv_word
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag      <= 1'b0;
      resv_word <= '0;
    end else if (lr_valid) begin
      flag      <= 1'b1;
      resv_word <= lr_word;
    end else if (sc_valid || snp_clear) begin
      flag      <= 1'b0;
    end
  end

  // R2
  lr_sets_chk: assert property (@(posedge clk) disable iff (rst)
    lr_valid |=> (flag && resv_word == $past(lr_word)));
  // R8
  sc_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && !lr_valid) |=> !flag);
  // R6
  snoop_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (snp_clear && !lr_valid) |=> !flag);
endmodule

// File: rtl/resv_out.sv
module resv_out #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int OFS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lr_valid,
  input  logic [AW-1:0] lr_addr,
  input  logic          sc_valid,
  input  logic          sc_pass,
  input  logic [AW-1:0] sc_addr,
  input  logic [DW-1:0] sc_data,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          st_en,
  output logic [AW-1:0] st_addr,
  output logic [DW-1:0] st_data,
  output logic          sc_done,
  output logic          sc_ok,
  output logic          bcast_valid,
  output logic [AW-1:0] bcast_addr
);
  import resv_pkg::*;
  sc_result_t res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en       <= 1'b0;
      rd_addr     <= '0;
      st_en       <= 1'b0;
      st_addr     <= '0;
      st_data     <= '0;
      res_q       <= '0;
      bcast_valid <= 1'b0;
      bcast_addr  <= '0;
    end else begin
      rd_en       <= lr_valid;
      rd_addr     <= lr_valid ? lr_addr : '0;
      res_q.done  <= sc_valid;
      res_q.ok    <= sc_valid && sc_pass;
      st_en       <= sc_valid && sc_pass;
      st_addr     <= (sc_valid && sc_pass) ? sc_addr : '0;
      st_data     <= (sc_valid && sc_pass) ? sc_data : '0;
      bcast_valid <= sc_valid && sc_pass;
      bcast_addr  <= (sc_valid && sc_pass) ? {sc_addr[AW-1:OFS], {OFS{1'b0}}} : '0;
    end
  end

  assign sc_done = res_q.done;
  assign sc_ok   = res_q.ok;

  // R3
  ok_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    sc_ok |-> sc_done);
  // R9
  bcast_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    bcast_valid |-> (st_en && bcast_addr[OFS-1:0] == '0));
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int OFS = 2,
  localparam int WW = AW - OFS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lr_valid,
  input  logic [AW-1:0] lr_addr,
  input  logic          sc_valid,
  input  logic [AW-1:0] sc_addr,
  input  logic [DW-1:0] sc_data,
  input  logic          snp_valid,
  input  logic [AW-1:0] snp_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          st_en,
  output logic [AW-1:0] st_addr,
  output logic [DW-1:0] st_data,
  output logic          sc_done,
  output logic          sc_ok,
  output logic          bcast_valid,
  output logic [AW-1:0] bcast_addr
);
  logic          flag;
  logic [WW-1:0] resv_word;
  logic [AW-1:0] resv_addr;
  logic          sc_hit;
  logic          snp_hit;
  logic          snp_clear;
  logic          sc_pass;

  assign resv_addr = {resv_word, {OFS{1'b0}}};

  resv_addr_cmp #(.AW(AW), .OFS(OFS)) u_cmp_sc (
    .a(sc_addr), .b(resv_addr), .same_word(sc_hit));

  resv_addr_cmp #(.AW(AW), .OFS(OFS)) u_cmp_snp (
    .a(snp_addr), .b(resv_addr), .same_word(snp_hit));

  assign snp_clear = snp_valid && snp_hit;
  assign sc_pass   = flag && sc_hit && !snp_clear;

  resv_state #(.AW(AW), .OFS(OFS)) u_state (
    .clk(clk), .rst(rst),
    .lr_valid(lr_valid), .lr_word(lr_addr[AW-1:OFS]),
    .sc_valid(sc_valid), .snp_clear(snp_clear),
    .flag(flag), .resv_word(resv_word));

  resv_out #(.AW(AW), .DW(DW), .OFS(OFS)) u_out (
    .clk(clk), .rst(rst),
    .lr_valid(lr_valid), .lr_addr(lr_addr),
    .sc_valid(sc_valid), .sc_pass(sc_pass),
    .sc_addr(sc_addr), .sc_data(sc_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .st_en(st_en), .st_addr(st_addr), .st_data(st_data),
    .sc_done(sc_done), .sc_ok(sc_ok),
    .bcast_valid(bcast_valid), .bcast_addr(bcast_addr));

  // R7
  snoop_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && snp_valid && snp_hit) |=> (sc_done && !sc_ok && !st_en));
  // R4
  store_needs_pass_chk: assert property (@(posedge clk) disable iff (rst)
    st_en |-> (sc_ok && sc_done));
  // R8
  no_flag_no_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (sc_valid && !flag) |=> !sc_ok);
endmodule

// File: tb/resv_monitor_bench.sv
module resv_monitor_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lr_valid = 1'b0, sc_valid = 1'b0, snp_valid = 1'b0;
  logic [31:0] lr_addr = '0, sc_addr = '0, sc_data = '0, snp_addr = '0;
  logic        rd_en, st_en, sc_done, sc_ok, bcast_valid;
  logic [31:0] rd_addr, st_addr, st_data, bcast_addr;
  logic [31:0] mem [16];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resv_monitor u_resv_monitor (
    .clk(clk), .rst(rst),
    .lr_valid(lr_valid), .lr_addr(lr_addr),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_data(sc_data),
    .snp_valid(snp_valid), .snp_addr(snp_addr),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .st_en(st_en), .st_addr(st_addr), .st_data(st_data),
    .sc_done(sc_done), .sc_ok(sc_ok),
    .bcast_valid(bcast_valid), .bcast_addr(bcast_addr));

  always @(posedge clk) if (st_en) mem[st_addr[5:2]] <= st_data;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus; returns at the next falling edge with inputs idle.
  task automatic step(logic lr, logic [31:0] la, logic sc, logic [31:0] sa,
                      logic [31:0] sd, logic sn, logic [31:0] na);
    lr_valid = lr; lr_addr = la;
    sc_valid = sc; sc_addr = sa; sc_data = sd;
    snp_valid = sn; snp_addr = na;
    @(negedge clk);
    lr_valid = 0; sc_valid = 0; snp_valid = 0;
    lr_addr = '0; sc_addr = '0; sc_data = '0; snp_addr = '0;
  endtask

  task automatic do_lr(logic [31:0] a);
    step(1, a, 0, '0, '0, 0, '0);
  endtask

  task automatic do_sc(logic [31:0] a, logic [31:0] d);
    step(0, '0, 1, a, d, 0, '0);
  endtask

  task automatic expect_sc(string req, logic ok, logic [31:0] a, logic [31:0] d);
    check(req, "sc_done", {31'b0, sc_done}, 32'd1);
    check(req, "sc_ok", {31'b0, sc_ok}, {31'b0, ok});
    check(req, "st_en", {31'b0, st_en}, {31'b0, ok});
    check(req, "bcast_valid", {31'b0, bcast_valid}, {31'b0, ok});
    if (ok) begin
      check(req, "st_addr", st_addr, a);
      check(req, "st_data", st_data, d);
      check(req, "bcast_addr", bcast_addr, {a[31:2], 2'b00});
    end
  endtask

  task automatic t_reset;
    check("R1", "st_en", {31'b0, st_en}, 0);
    check("R1", "rd_en", {31'b0, rd_en}, 0);
    check("R1", "sc_done", {31'b0, sc_done}, 0);
    check("R1", "bcast_valid", {31'b0, bcast_valid}, 0);
    do_sc(32'h0, 32'h1);
    expect_sc("R1", 0, 32'h0, 32'h1);
  endtask

  task automatic t_basic;
    do_lr(32'h40);
    check("R2", "rd_en", {31'b0, rd_en}, 1);
    check("R2", "rd_addr", rd_addr, 32'h40);
    check("R9", "bcast_valid idle", {31'b0, bcast_valid}, 0);
    do_sc(32'h40, 32'hCAFE0001);
    expect_sc("R3", 1, 32'h40, 32'hCAFE0001);
    step(0, '0, 0, '0, '0, 0, '0);
    check("R3", "mem", mem[4'h0], 32'hCAFE0001);
    check("R3", "idle sc_done", {31'b0, sc_done}, 0);
    do_sc(32'h40, 32'h2);
    expect_sc("R8", 0, 32'h40, 32'h2);
  endtask

  task automatic t_word;
    do_lr(32'h40);
    do_sc(32'h44, 32'h3);
    expect_sc("R5", 0, 32'h44, 32'h3);
    do_sc(32'h40, 32'h4);
    expect_sc("R8", 0, 32'h40, 32'h4);
    do_lr(32'h43);
    do_sc(32'h41, 32'h5);
    expect_sc("R5", 1, 32'h41, 32'h5);
    check("R9", "bcast_addr aligned", bcast_addr, 32'h40);
  endtask

  task automatic t_snoop;
    do_lr(32'h80);
    step(0, '0, 0, '0, '0, 1, 32'h82);
    do_sc(32'h80, 32'h6);
    expect_sc("R6", 0, 32'h80, 32'h6);
    do_lr(32'h80);
    step(0, '0, 0, '0, '0, 1, 32'h84);
    do_sc(32'h80, 32'h7);
    expect_sc("R6", 1, 32'h80, 32'h7);
  endtask

  task automatic t_collide;
    do_lr(32'h90);
    step(0, '0, 1, 32'h90, 32'h8, 1, 32'h90);
    expect_sc("R7", 0, 32'h90, 32'h8);
    do_lr(32'h90);
    step(0, '0, 1, 32'h90, 32'h9, 1, 32'h94);
    expect_sc("R7", 1, 32'h90, 32'h9);
  endtask

  task automatic t_replace;
    do_lr(32'hA0);
    do_lr(32'hB0);
    do_sc(32'hA0, 32'hA);
    expect_sc("R11", 0, 32'hA0, 32'hA);
    do_lr(32'hB0);
    do_sc(32'hB0, 32'hB);
    expect_sc("R11", 1, 32'hB0, 32'hB);
  endtask

  task automatic t_lr_same_cycle;
    do_lr(32'hC0);
    step(1, 32'hD0, 1, 32'hC0, 32'hC, 0, '0);
    expect_sc("R10", 1, 32'hC0, 32'hC);
    check("R10", "rd_addr", rd_addr, 32'hD0);
    do_sc(32'hD0, 32'hD);
    expect_sc("R10", 1, 32'hD0, 32'hD);
    step(1, 32'hE0, 0, '0, '0, 1, 32'hE0);
    do_sc(32'hE0, 32'hE);
    expect_sc("R10", 1, 32'hE0, 32'hE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_word();
    t_snoop();
    t_collide();
    t_replace();
    t_lr_same_cycle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule